// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block is the synchronous read front end of a NOR flash model. While burst mode is off it behaves as a plain asynchronous read path. The address input goes straight through, the word at that address is returned, and ready stays high. Once burst mode is enabled through the configuration port, a strobe on `avd_i` latches a starting word address. After a programmable number of wait cycles the block steps through the array on every active clock edge, driving the current address, the stored word and a ready flag.

Two address orders are available. In linear mode the address wraps inside an aligned group of 8, 16 or 32 words. In continuous mode it counts up through the array and inserts one wait cycle at each internal 64-word boundary. The active edge is selectable and may be rising or falling. The host can suspend a burst and later resume it from the same point. A reduced wait option shortens the start-up latency by one cycle when the burst starts at an even address. The array is a stub whose word at address `a` is `a XOR SEED`.

Top module: `burst_read_seq`

## Requirements
- R1: While `rst_ni` is low the configuration returns to asynchronous mode with the following fields: wait select 3, continuous order, rising edge, reduced option off. In asynchronous mode `rdy_o` is 1, `addr_o` equals `addr_i`, `data_o` is the word at `addr_i`, and `avd_i` has no effect.
- R2: A high `cfg_we_i` at a rising `clk_i` loads `cfg_i` with this layout:
  - bits [2:0] are the wait select W.
  - bits [4:3] set the order: 00 continuous, 01 wrap 8, 10 wrap 16, 11 wrap 32.
  - bit [5] enables burst mode.
  - bit [6] selects the falling edge.
  - bit [7] enables the reduced wait option.
- R3: In burst mode, a high `avd_i` at an active edge latches `addr_i`. `rdy_o` then stays low for W+2 active-edge cycles and rises with `addr_o` equal to the start address.
- R4: With the reduced option on, a burst that starts at an even address waits W+1 cycles. One that starts at an odd address still waits W+2.
- R5: In the wrap orders, each active edge with `rdy_o` high moves to the next word inside the aligned 8-, 16- or 32-word group, returning to the group base after its last word.
- R6: In continuous order the address increments by one on each edge. After the last word of a 64-word block, one cycle with `rdy_o` low and `addr_o` held is inserted before the next block's first word.
- R7: While `suspend_i` is high at active edges during a burst, `rdy_o` is low, and the address, the data and the remaining wait count are frozen. After release the burst continues with the word that follows the last word delivered.
- R8: When the falling edge is selected, every burst step happens on the falling edge of `clk_i`, and nothing changes on the rising edge.
- R9: Whenever `rdy_o` is high in burst mode, `data_o` equals `addr_o XOR 16'hC3A5`.
- R10: A new `avd_i` strobe in the middle of a burst abandons it and starts a fresh wait from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | 8 | Configuration word |
| avd_i | input | 1 | Address-valid strobe, starts a burst |
| addr_i | input | ADDR_W (16) | Start address, or read address in asynchronous mode |
| suspend_i | input | 1 | Hold the burst in place |
| addr_o | output | ADDR_W (16) | Current array address |
| data_o | output | DATA_W (16) | Array word at `addr_o` |
| rdy_o | output | 1 | Output data valid |

## Verification
Some behaviours are checked on every active edge, whichever clock edge is selected:
- a strobe always drops ready on the next cycle;
- consecutive ready cycles stay inside the wrap group or step by exactly one;
- a 64-word crossing always produces a held bubble;
- suspension always freezes the address and drops ready.

Other behaviours can only be shown by the directed scenarios:
- the exact wait lengths, including the odd/even difference under the reduced option;
- the data values;
- the wrap points and the resume position after a suspend;
- that nothing moves on the rising edge when the falling edge is selected.

// File: rtl/burst_read_pkg.sv
package burst_read_pkg;

  typedef enum logic [1:0] {
    BL_CONT = 2'b00,
    BL_8    = 2'b01,
    BL_16   = 2'b10,
    BL_32   = 2'b11
  } blen_e;

  localparam int unsigned WSEL_W = 3;

  typedef struct packed {
    logic              reduced;
    logic              fall;
    logic              sync;
    blen_e             blen;
    logic [WSEL_W-1:0] wait_sel;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

  localparam cfg_t CFG_RESET = '{reduced: 1'b0, fall: 1'b0, sync: 1'b0,
                                 blen: BL_CONT, wait_sel: 3'd3};

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DATA, ST_GAP} st_e;

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import burst_read_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] data_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RESET;
    else if (we_i) cfg_q <= cfg_t'(data_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen
  import burst_read_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  blen_e             blen_i,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] mask;

  assign inc = cur_i + ADDR_W'(1);

  always_comb begin
    unique case (blen_i)
      BL_8:    mask = ADDR_W'(7);
      BL_16:   mask = ADDR_W'(15);
      BL_32:   mask = ADDR_W'(31);
      default: mask = '1;
    endcase
  end

  // low bits advance, group bits stay
  assign nxt_o = (cur_i & ~mask) | (inc & mask);
endmodule

// File: rtl/brs_array_stub.sv
module brs_array_stub #(
  parameter int unsigned       ADDR_W = 16,
  parameter int unsigned       DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED   = 'hC3A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] async_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] async_data_o
);
  function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
    return DATA_W'(a) ^ SEED;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= word_at(rd_addr_i);
  end

  assign async_data_o = word_at(async_addr_i);
endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import burst_read_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned GAP_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  blen_e             blen_i,
  input  logic [WSEL_W-1:0] wait_sel_i,
  input  logic              reduced_i,
  input  logic              avd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              suspend_i,
  input  logic [ADDR_W-1:0] nxt_i,
  output logic [ADDR_W-1:0] cur_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              valid_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = WSEL_W + 1;

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              susp_q, susp_d;
  logic              long_start;

  // reduced option saves one cycle only on even start addresses
  assign long_start = !(reduced_i && !addr_i[0]);

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    cnt_d     = cnt_q;
    susp_d    = susp_q;
    rd_en_o   = 1'b0;
    rd_addr_o = cur_q;
    if (!sync_i) begin
      st_d   = ST_IDLE;
      susp_d = 1'b0;
    end else if (avd_i) begin
      st_d      = ST_WAIT;
      cur_d     = addr_i;
      cnt_d     = CNT_W'(wait_sel_i) + CNT_W'(long_start);
      susp_d    = 1'b0;
      rd_en_o   = 1'b1;
      rd_addr_o = addr_i;
    end else if (st_q != ST_IDLE && suspend_i) begin
      susp_d = 1'b1;
    end else begin
      susp_d = 1'b0;
      unique case (st_q)
        ST_WAIT: begin
          if (cnt_q == '0) st_d = ST_DATA;
          else             cnt_d = cnt_q - CNT_W'(1);
        end
        ST_DATA: begin
          if (blen_i == BL_CONT && (&cur_q[GAP_W-1:0])) begin
            st_d = ST_GAP;
          end else begin
            cur_d     = nxt_i;
            rd_en_o   = 1'b1;
            rd_addr_o = nxt_i;
          end
        end
        ST_GAP: begin
          st_d      = ST_DATA;
          cur_d     = nxt_i;
          rd_en_o   = 1'b1;
          rd_addr_o = nxt_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      cnt_q  <= '0;
      susp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      cnt_q  <= cnt_d;
      susp_q <= susp_d;
    end
  end

  assign cur_o   = cur_q;
  assign valid_o = (st_q == ST_DATA) && !susp_q;
  assign busy_o  = (st_q != ST_IDLE);
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_read_pkg::*;
#(
  parameter int unsigned       ADDR_W = 16,
  parameter int unsigned       DATA_W = 16,
  parameter int unsigned       GAP_W  = 6,
  parameter logic [DATA_W-1:0] SEED   = 'hC3A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              avd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              suspend_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o
);
  cfg_t              cfg_q;
  logic              core_clk;
  logic [ADDR_W-1:0] cur, nxt, rd_addr;
  logic              rd_en, valid, busy;
  logic [DATA_W-1:0] rd_data, async_data;

  brs_cfg_reg i_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .data_i(cfg_i),
    .cfg_o (cfg_q)
  );

  // edge select: change only while no burst runs
  assign core_clk = clk_i ^ cfg_q.fall;

  brs_addr_gen #(.ADDR_W(ADDR_W)) i_agen (
    .cur_i (cur),
    .blen_i(cfg_q.blen),
    .nxt_o (nxt)
  );

  brs_ctrl #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) i_ctrl (
    .clk_i     (core_clk),
    .rst_ni    (rst_ni),
    .sync_i    (cfg_q.sync),
    .blen_i    (cfg_q.blen),
    .wait_sel_i(cfg_q.wait_sel),
    .reduced_i (cfg_q.reduced),
    .avd_i     (avd_i),
    .addr_i    (addr_i),
    .suspend_i (suspend_i),
    .nxt_i     (nxt),
    .cur_o     (cur),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .valid_o   (valid),
    .busy_o    (busy)
  );

  brs_array_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) i_arr (
    .clk_i       (core_clk),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en),
    .rd_addr_i   (rd_addr),
    .async_addr_i(addr_i),
    .rd_data_o   (rd_data),
    .async_data_o(async_data)
  );

  assign addr_o = cfg_q.sync ? cur     : addr_i;
  assign data_o = cfg_q.sync ? rd_data : async_data;
  assign rdy_o  = cfg_q.sync ? valid   : 1'b1;
endmodule

// File: rtl/burst_read_chk.sv
module burst_read_chk
  import burst_read_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned GAP_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input cfg_t              cfg_i,
  input logic              avd_i,
  input logic              suspend_i,
  input logic              busy_i,
  input logic              rdy_i,
  input logic [ADDR_W-1:0] bus_addr_i
);
  a_r3_strobe_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.sync && avd_i) |=> (!rdy_i || $past(cfg_i) != cfg_i));

  a_r5_wrap_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.sync && cfg_i.blen != BL_CONT && rdy_i && $past(rdy_i) && $past(cfg_i) == cfg_i)
    |-> ((bus_addr_i >> (int'(cfg_i.blen) + 2)) == ($past(bus_addr_i) >> (int'(cfg_i.blen) + 2))));

  a_r6_cont_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.sync && cfg_i.blen == BL_CONT && rdy_i && $past(rdy_i) && $past(cfg_i) == cfg_i)
    |-> (bus_addr_i == $past(bus_addr_i) + ADDR_W'(1)));

  a_r6_gap_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.sync && cfg_i.blen == BL_CONT && rdy_i && (&bus_addr_i[GAP_W-1:0]) && !avd_i && !suspend_i)
    |=> ((!rdy_i && $stable(bus_addr_i)) || $past(cfg_i) != cfg_i));

  a_r7_suspend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.sync && busy_i && suspend_i && !avd_i)
    |=> ((!rdy_i && $stable(bus_addr_i)) || $past(cfg_i) != cfg_i));
endmodule

bind burst_read_seq burst_read_chk #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) i_chk (
  .clk_i     (core_clk),
  .rst_ni    (rst_ni),
  .cfg_i     (cfg_q),
  .avd_i     (avd_i),
  .suspend_i (suspend_i),
  .busy_i    (busy),
  .rdy_i     (rdy_o),
  .bus_addr_i(addr_o)
);

// File: tb/test_burst_read_seq.sv
`timescale 1ns/1ps
module test_burst_read_seq;
  import burst_read_pkg::*;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 16;
  localparam logic [15:0] SEED = 16'hC3A5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [CFG_W-1:0]  cfg = '0;
  logic              avd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              suspend = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic [DATA_W-1:0] data_o;
  logic              rdy_o;

  int checks = 0;
  int fails = 0;
  bit fall_mode = 1'b0;
  bit done = 1'b0;

  burst_read_seq i_burst_read_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_i(cfg),
    .avd_i(avd), .addr_i(addr), .suspend_i(suspend),
    .addr_o(addr_o), .data_o(data_o), .rdy_o(rdy_o)
  );

  function automatic logic [15:0] word(input logic [15:0] a);
    return a ^ SEED;
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] a, input int len);
    logic [15:0] m;
    m = (len == 0) ? 16'hFFFF : 16'(len - 1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic act_edge();
    if (fall_mode) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input bit red, input bit fall, input bit sync,
                           input logic [1:0] blen, input logic [2:0] wsel);
    @(posedge clk); #1;
    cfg_we = 1'b1;
    cfg = {red, fall, sync, blen, wsel};
    @(posedge clk); #1;
    cfg_we = 1'b0;
    fall_mode = fall;
  endtask

  task automatic start_burst(input logic [15:0] a);
    avd = 1'b1;
    addr = a;
    act_edge();
    avd = 1'b0;
    addr = 16'hFFFF;
  endtask

  task automatic expect_wait(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, "rdy low during wait", 32'(rdy_o), 32'd0);
      act_edge();
    end
  endtask

  task automatic expect_word(input logic [15:0] a, input string req);
    chk(req, "rdy", 32'(rdy_o), 32'd1);
    chk(req, "addr", 32'(addr_o), 32'(a));
    chk("R9", "data", 32'(data_o), 32'(word(a)));
  endtask

  task automatic t_reset_async();
    addr = 16'h1234;
    #1;
    chk("R1", "async rdy", 32'(rdy_o), 32'd1);
    chk("R1", "async addr", 32'(addr_o), 32'h1234);
    chk("R1", "async data", 32'(data_o), 32'(word(16'h1234)));
    avd = 1'b1;
    addr = 16'h0055;
    act_edge();
    act_edge();
    avd = 1'b0;
    chk("R1", "avd ignored rdy", 32'(rdy_o), 32'd1);
    chk("R1", "avd ignored addr", 32'(addr_o), 32'h0055);
  endtask

  task automatic t_wrap8_wait();
    logic [15:0] a;
    write_cfg(1'b0, 1'b0, 1'b1, 2'b01, 3'd2);
    start_burst(16'h0013);
    expect_wait(4, "R2");
    a = 16'h0013;
    for (int k = 0; k < 10; k++) begin
      expect_word(a, "R5");
      act_edge();
      a = nxt(a, 8);
    end
  endtask

  task automatic t_reduced();
    write_cfg(1'b1, 1'b0, 1'b1, 2'b10, 3'd1);
    start_burst(16'h0020);
    expect_wait(2, "R4");
    expect_word(16'h0020, "R4");
    start_burst(16'h0021);
    expect_wait(3, "R4");
    expect_word(16'h0021, "R4");
    start_burst(16'h002E);
    expect_wait(2, "R4");
    expect_word(16'h002E, "R5");
    act_edge(); expect_word(16'h002F, "R5");
    act_edge(); expect_word(16'h0020, "R5");
    act_edge(); expect_word(16'h0021, "R5");
  endtask

  task automatic t_wrap32();
    write_cfg(1'b0, 1'b0, 1'b1, 2'b11, 3'd0);
    start_burst(16'h003E);
    expect_wait(2, "R3");
    expect_word(16'h003E, "R5");
    act_edge(); expect_word(16'h003F, "R5");
    act_edge(); expect_word(16'h0020, "R5");
    act_edge(); expect_word(16'h0021, "R5");
  endtask

  task automatic t_continuous();
    write_cfg(1'b0, 1'b0, 1'b1, 2'b00, 3'd0);
    start_burst(16'h007D);
    expect_wait(2, "R3");
    expect_word(16'h007D, "R6");
    act_edge(); expect_word(16'h007E, "R6");
    act_edge(); expect_word(16'h007F, "R6");
    act_edge();
    chk("R6", "gap rdy", 32'(rdy_o), 32'd0);
    chk("R6", "gap addr held", 32'(addr_o), 32'h007F);
    act_edge(); expect_word(16'h0080, "R6");
    act_edge(); expect_word(16'h0081, "R6");
  endtask

  task automatic t_suspend();
    write_cfg(1'b0, 1'b0, 1'b1, 2'b01, 3'd0);
    start_burst(16'h0044);
    expect_wait(2, "R3");
    expect_word(16'h0044, "R7");
    act_edge(); expect_word(16'h0045, "R7");
    suspend = 1'b1;
    for (int i = 0; i < 2; i++) begin
      act_edge();
      chk("R7", "susp rdy", 32'(rdy_o), 32'd0);
      chk("R7", "susp addr", 32'(addr_o), 32'h0045);
      chk("R7", "susp data", 32'(data_o), 32'(word(16'h0045)));
    end
    suspend = 1'b0;
    act_edge(); expect_word(16'h0046, "R7");
    act_edge(); expect_word(16'h0047, "R7");
    start_burst(16'h0050);
    suspend = 1'b1;
    act_edge();
    act_edge();
    suspend = 1'b0;
    expect_wait(2, "R7");
    expect_word(16'h0050, "R7");
  endtask

  task automatic t_restart();
    write_cfg(1'b0, 1'b0, 1'b1, 2'b01, 3'd0);
    start_burst(16'h0060);
    expect_wait(2, "R10");
    expect_word(16'h0060, "R10");
    act_edge(); expect_word(16'h0061, "R10");
    start_burst(16'h0100);
    expect_wait(2, "R10");
    expect_word(16'h0100, "R10");
  endtask

  task automatic t_falling();
    write_cfg(1'b0, 1'b1, 1'b1, 2'b01, 3'd0);
    start_burst(16'h0070);
    expect_wait(2, "R8");
    expect_word(16'h0070, "R8");
    @(posedge clk); #1;
    chk("R8", "no step on rising", 32'(addr_o), 32'h0070);
    chk("R8", "rdy kept on rising", 32'(rdy_o), 32'd1);
    @(negedge clk); #1;
    expect_word(16'h0071, "R8");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_async();
    t_wrap8_wait();
    t_reduced();
    t_wrap32();
    t_continuous();
    t_suspend();
    t_restart();
    t_falling();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule